// File: doc/BRIEF.md
# Frequency-Select Watchdog with Safe-Code Fallback

This block guards the frequency selection of a clock generator against a configuration agent that has stopped responding. A down-counter advances on a slow timebase tick (one tick per 293 ms in silicon, a scaled tick in simulation). The agent must service the watchdog before the programmed number of ticks runs out. If it does not, the watchdog raises a sticky alarm flag and replaces the live frequency-select code with a stored safe code. Nothing is reset; only the selection changes.

Three configuration fields are written through a single field-select write port: the timeout in ticks, the enable, and the safe code. The alarm flag has its own write strobe. Writing zero to it clears the alarm, restores the live code and restarts the countdown. Building the PLL and the output clocks is outside this block.

Top module: `freq_watchdog`

## Requirements
- R1: After reset the alarm output is 0 and `eff_code_o` equals `cur_code_i`.
- R2: Reset loads a timeout of 16 ticks, enable 0 and safe code 5'b10000. The fields are written with `wr_sel_i` (bit 0 timeout = `wr_data_i[7:0]`, bit 1 enable = `wr_data_i[0]`, bit 2 safe code = `wr_data_i[4:0]`) and take effect on the next cycle.
- R3: While the enable is 0, ticks do not move the counter and no alarm is raised.
- R4: With timeout N ≥ 1, the alarm sets on the Nth enabled tick after the last reload. With timeout 0 it sets on the first enabled tick.
- R5: A service pulse while enabled reloads the counter with the timeout. A service pulse while disabled has no effect. A reload in the same cycle as a tick wins over the tick.
- R6: A write that turns the enable from 0 to 1 reloads the counter with the timeout in effect after that write (a timeout written in the same cycle is used).
- R7: While the alarm is set, `eff_code_o` equals the stored safe code, including a safe code rewritten during the alarm. The alarm stays set through ticks and service pulses until it is cleared.
- R8: A status write of 0 (`stat_we_i` = 1, `stat_wdata_i` = 0) clears the alarm and reloads the counter, so `eff_code_o` again follows `cur_code_i`. A status write of 1 has no effect.
- R9: When the alarm is clear, `eff_code_o` follows `cur_code_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one cycle per unit |
| svc_i | input | 1 | Service pulse |
| wr_sel_i | input | 3 | Field write strobes: timeout, enable, safe code |
| wr_data_i | input | 8 | Write data for the selected fields |
| stat_we_i | input | 1 | Alarm status write strobe |
| stat_wdata_i | input | 1 | Status write data; 0 clears the alarm |
| cur_code_i | input | 5 | Live frequency-select code |
| alarm_o | output | 1 | Alarm status |
| eff_code_o | output | 5 | Effective frequency-select code |

## Verification
The embedded assertions check on every cycle that no alarm appears while the watchdog is disabled and that the counter holds then. They also check that the alarm stays set until a clearing write, that a clearing write always drops it, and that an uninterrupted enabled tick decrements the counter by exactly one. The bench scenarios are needed for the points a single-cycle property cannot show: the reset defaults (the sixteen-tick interval and the 5'b10000 fallback), the exact tick on which the alarm fires, a zero timeout, reload priority over a coincident tick, and the ignored status write of 1.

// File: rtl/freq_wdg_pkg.sv
package freq_wdg_pkg;
    parameter int unsigned TMO_W    = 8;
    parameter int unsigned CODE_W   = 5;
    parameter int unsigned FIELD_N  = 3;
    parameter logic [TMO_W-1:0]  TMO_RST  = 8'd16;
    parameter logic [CODE_W-1:0] SAFE_RST = 5'b10000;

    localparam int unsigned F_TMO  = 0;
    localparam int unsigned F_EN   = 1;
    localparam int unsigned F_SAFE = 2;

    typedef struct packed {
        logic [TMO_W-1:0]  tmo;
        logic              en;
        logic [CODE_W-1:0] safe;
    } cfg_t;

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             alarm;
    } tmr_t;
endpackage

// File: rtl/freq_wdg_cfg.sv
module freq_wdg_cfg
    import freq_wdg_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [FIELD_N-1:0] wr_sel_i,
    input  logic [TMO_W-1:0]   wr_data_i,
    output logic [TMO_W-1:0]   tmo_o,
    output logic               en_o,
    output logic [CODE_W-1:0]  safe_o,
    output logic               arm_o,
    output logic [TMO_W-1:0]   load_val_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_sel_i[F_TMO])  cfg_d.tmo  = wr_data_i;
        if (wr_sel_i[F_EN])   cfg_d.en   = wr_data_i[0];
        if (wr_sel_i[F_SAFE]) cfg_d.safe = wr_data_i[CODE_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.tmo  <= TMO_RST;
            cfg_q.en   <= 1'b0;
            cfg_q.safe <= SAFE_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign tmo_o      = cfg_q.tmo;
    assign en_o       = cfg_q.en;
    assign safe_o     = cfg_q.safe;
    assign arm_o      = cfg_d.en && !cfg_q.en;
    assign load_val_o = cfg_d.tmo;

    // R2: an untouched field keeps its value
    a_r2_tmo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_sel_i[F_TMO] |=> $stable(cfg_q.tmo));
endmodule

// File: rtl/freq_wdg_timer.sv
module freq_wdg_timer
    import freq_wdg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             svc_i,
    input  logic             clr_i,
    input  logic             arm_i,
    input  logic             en_i,
    input  logic [TMO_W-1:0] load_val_i,
    output logic             alarm_o
);
    tmr_t tmr_d, tmr_q;
    logic reload;

    always_comb begin
        tmr_d  = tmr_q;
        reload = arm_i || clr_i || (svc_i && en_i);
        if (clr_i) tmr_d.alarm = 1'b0;
        if (reload) begin
            tmr_d.cnt = load_val_i;
        end else if (en_i && tick_i && !tmr_q.alarm) begin
            if (tmr_q.cnt <= TMO_W'(1)) begin
                tmr_d.cnt   = '0;
                tmr_d.alarm = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - TMO_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q.cnt   <= TMO_RST;
            tmr_q.alarm <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign alarm_o = tmr_q.alarm;

    a_r3_no_alarm_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !tmr_q.alarm) |=> !tmr_q.alarm);
    a_r3_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !arm_i && !clr_i) |=> $stable(tmr_q.cnt));
    a_r4_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && tick_i && !reload && !tmr_q.alarm && tmr_q.cnt > TMO_W'(1))
        |=> tmr_q.cnt == $past(tmr_q.cnt) - TMO_W'(1));
    a_r7_alarm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.alarm && !clr_i) |=> tmr_q.alarm);
    a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !tmr_q.alarm);
endmodule

// File: rtl/freq_wdg_sel.sv
module freq_wdg_sel
    import freq_wdg_pkg::*;
(
    input  logic              alarm_i,
    input  logic [CODE_W-1:0] safe_i,
    input  logic [CODE_W-1:0] cur_i,
    output logic [CODE_W-1:0] eff_o
);
    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        assign eff_o[b] = alarm_i ? safe_i[b] : cur_i[b];
    end
endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
    import freq_wdg_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               svc_i,
    input  logic [FIELD_N-1:0] wr_sel_i,
    input  logic [TMO_W-1:0]   wr_data_i,
    input  logic               stat_we_i,
    input  logic               stat_wdata_i,
    input  logic [CODE_W-1:0]  cur_code_i,
    output logic               alarm_o,
    output logic [CODE_W-1:0]  eff_code_o
);
    logic [TMO_W-1:0]  tmo, load_val;
    logic              en, arm, clr;
    logic [CODE_W-1:0] safe;

    assign clr = stat_we_i && !stat_wdata_i;

    freq_wdg_cfg u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .tmo_o      (tmo),
        .en_o       (en),
        .safe_o     (safe),
        .arm_o      (arm),
        .load_val_o (load_val)
    );

    freq_wdg_timer u_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .svc_i      (svc_i),
        .clr_i      (clr),
        .arm_i      (arm),
        .en_i       (en),
        .load_val_i (load_val),
        .alarm_o    (alarm_o)
    );

    freq_wdg_sel u_sel (
        .alarm_i (alarm_o),
        .safe_i  (safe),
        .cur_i   (cur_code_i),
        .eff_o   (eff_code_o)
    );

    // R8: a status write of 1 never raises the alarm by itself
    a_r8_set_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_we_i && stat_wdata_i && !alarm_o && !(en && tick_i)) |=> !alarm_o);

    logic unused_tmo;
    assign unused_tmo = ^tmo;
endmodule

// File: tb/freq_watchdog_tb_top.sv
module freq_watchdog_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, svc = 1'b0, swe = 1'b0, swd = 1'b0;
    logic [2:0] wsel = '0;
    logic [7:0] wdat = '0;
    logic [4:0] cur = 5'h03;
    logic       alarm;
    logic [4:0] eff;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    logic [7:0] m_tmo, m_cnt;
    logic       m_en, m_alarm;
    logic [4:0] m_safe;

    always #5 clk = ~clk;

    freq_watchdog dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .svc_i(svc),
        .wr_sel_i(wsel), .wr_data_i(wdat), .stat_we_i(swe), .stat_wdata_i(swd),
        .cur_code_i(cur), .alarm_o(alarm), .eff_code_o(eff)
    );

    function automatic logic [4:0] exp_eff();
        return m_alarm ? m_safe : cur;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic arm, clr, rel;
        logic [7:0] ld;
        arm = wsel[1] && wdat[0] && !m_en;
        ld  = wsel[0] ? wdat : m_tmo;
        clr = swe && !swd;
        rel = arm || clr || (svc && m_en);
        if (clr) m_alarm = 1'b0;
        if (rel) m_cnt = ld;
        else if (m_en && tick && !m_alarm) begin
            if (m_cnt <= 8'd1) begin m_cnt = 0; m_alarm = 1'b1; end
            else m_cnt = m_cnt - 8'd1;
        end
        if (wsel[0]) m_tmo = wdat;
        if (wsel[1]) m_en = wdat[0];
        if (wsel[2]) m_safe = wdat[4:0];
    endtask

    // one clock: inputs already set, update model at edge, sample 1 ns later, clear pulses
    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        #1;
        chk({tag, " alarm"}, {7'd0, alarm}, {7'd0, m_alarm});
        chk({tag, " code"}, {3'd0, eff}, {3'd0, exp_eff()});
        tick = 0; svc = 0; swe = 0; swd = 0; wsel = 0; wdat = 0;
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin tick = 1; cyc(tag); end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d, input string tag);
        wsel = s; wdat = d; cyc(tag);
    endtask

    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog: run hung");
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        m_tmo = 8'd16; m_cnt = 8'd16; m_en = 0; m_alarm = 0; m_safe = 5'b10000;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset alarm", {7'd0, alarm}, 8'd0);
        chk("R1 reset code", {3'd0, eff}, 8'h03);
        rst_n = 1;
        @(posedge clk); #1;

        // R3: disabled, many ticks, no alarm
        ticks(40, "R3");
        chk("R3 disabled no alarm", {7'd0, alarm}, 8'd0);

        // R2/R6: enable only, default 16 ticks, default safe code
        wr(3'b010, 8'h01, "R6 enable");
        ticks(15, "R2");
        chk("R2 no alarm at 15", {7'd0, alarm}, 8'd0);
        ticks(1, "R4");
        chk("R2 alarm at 16", {7'd0, alarm}, 8'd1);
        chk("R2 default safe code", {3'd0, eff}, 8'h10);

        // R7: sticky through ticks and service, safe rewrite visible
        svc = 1; tick = 1; cyc("R7");
        ticks(5, "R7");
        wr(3'b100, 8'h0A, "R7 safe rewrite");
        chk("R7 new safe code", {3'd0, eff}, 8'h0A);

        // R8: write 1 ignored, write 0 clears
        swe = 1; swd = 1; cyc("R8 set");
        chk("R8 write one ignored", {7'd0, alarm}, 8'd1);
        cur = 5'h07;
        swe = 1; swd = 0; cyc("R8 clr");
        chk("R8 cleared", {7'd0, alarm}, 8'd0);
        chk("R9 code follows live", {3'd0, eff}, 8'h07);

        // R5: service before expiry, coincident tick
        wr(3'b001, 8'd3, "R5 tmo");
        svc = 1; cyc("R5 svc");
        ticks(2, "R5");
        svc = 1; tick = 1; cyc("R5 svc+tick");
        ticks(2, "R5");
        chk("R5 reload beat tick", {7'd0, alarm}, 8'd0);
        ticks(1, "R5");
        chk("R5 expired after reload", {7'd0, alarm}, 8'd1);

        // R4: timeout zero fires on first tick
        wr(3'b011, 8'd0, "R4 disable+tmo0");
        swe = 1; swd = 0; cyc("R4 clr");
        wr(3'b010, 8'h01, "R6 re-enable");
        chk("R4 no alarm before tick", {7'd0, alarm}, 8'd0);
        ticks(1, "R4 zero");
        chk("R4 zero timeout alarm", {7'd0, alarm}, 8'd1);

        // R5: service while disabled has no effect
        swe = 1; swd = 0; wsel = 3'b011; wdat = 8'd2; cyc("R5 dis");
        svc = 1; cyc("R5 svc dis");
        ticks(4, "R3 dis");
        chk("R5 disabled service no alarm", {7'd0, alarm}, 8'd0);

        // random phase
        void'($urandom(32'h5EED));
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            tick = ($urandom_range(0, 2) == 0);
            svc  = ($urandom_range(0, 9) == 0);
            cur  = 5'($urandom);
            if (r < 6) begin wsel = 3'b001; wdat = 8'($urandom_range(0, 6)); end
            else if (r < 10) begin wsel = 3'b010; wdat = 8'($urandom_range(0, 1)); end
            else if (r < 12) begin wsel = 3'b100; wdat = 8'($urandom); end
            else if (r < 15) begin swe = 1; swd = 1'($urandom); end
            cyc("R4/R7 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule